// File: doc/BRIEF.md
# Shared Control Bus Priority Arbiter

This block decides which system module owns a shared control bus. Only one owner is allowed at a time. Each of `N_MOD` bus modules has two priority numbers, set by static configuration. A lower number means a stronger claim. A module that needs only one number sets both fields to the same value.

The processor module is a separate requester. It always sits in the weakest slot on the bus. Inside that slot, a second-level resolver gives the I/O processor precedence over the CPU, so the CPU ranks last in the whole system.

Ownership is non-preemptive. A grant is held until the owner pulses its release line, even if a stronger requester arrives in the meantime. The bus is then free for one cycle, during which the next arbitration is made.

Top module: `bus_arb`

## Requirements
- R1: While `rst_ni` is low, every grant output and `busy_o` are low.
- R2: At most one of `gnt_o`, `iop_gnt_o` and `cpu_gnt_o` is high in any cycle, and `busy_o` is high exactly when one of them is.
- R3: When the bus is free and at least one request is present in a cycle, the chosen grant is high from the next clock edge. With no request, the bus stays free.
- R4: Each bus module's effective number is the smaller of its two configured fields. Among competing bus modules, the smallest effective number wins. Equal numbers go to the lower module index.
- R5: A bus module whose second field is below its first is arbitrated at the second field.
- R6: A grant stays high, and `busy_o` stays high, until the owner's release line is sampled high. Requests from any other requester, including stronger ones, do not remove it.
- R7: The owner's release pulse clears the grant at the next edge, leaving the bus free for one cycle. A release pulse from a requester that does not own the bus is ignored.
- R8: Any bus module request beats an I/O processor or CPU request made in the same cycle.
- R9: When the I/O processor and the CPU both request a free bus with no bus module requesting, the I/O processor is granted.
- R10: Priority fields are captured only around reset: while `rst_ni` is low and on the first edge after it rises. Later changes to `prio_a_i` and `prio_b_i` do not affect arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prio_a_i | input | N_MOD*PRIO_W | First priority field per bus module, module 0 in the low bits |
| prio_b_i | input | N_MOD*PRIO_W | Second priority field per bus module, module 0 in the low bits |
| req_i | input | N_MOD | Bus module request lines |
| rel_i | input | N_MOD | Bus module release pulses |
| iop_req_i | input | 1 | I/O processor request |
| iop_rel_i | input | 1 | I/O processor release pulse |
| cpu_req_i | input | 1 | CPU request |
| cpu_rel_i | input | 1 | CPU release pulse |
| gnt_o | output | N_MOD | One-hot bus module grants |
| iop_gnt_o | output | 1 | I/O processor grant |
| cpu_gnt_o | output | 1 | CPU grant |
| busy_o | output | 1 | Bus currently owned |

## Verification
The bench releases one owner after another while five requests stay pending. This walks the full precedence order down to the CPU; an arbiter with the order wrong hands out grants out of sequence. A strong request that arrives while the CPU owns the bus must wait, as must a release pulse from a non-owner. A preemptive design or one that honours stray releases would switch owner early. Separate resets cover three cases: equal numbers (a design without the index tie-break grants the upper module), a smaller second field (a design that reads only one field picks the wrong module), and configuration changes after reset (a design that tracks its inputs live would follow them).

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  typedef enum logic {
    ARB_FREE  = 1'b0,
    ARB_OWNED = 1'b1
  } arb_state_e;
endpackage

// File: rtl/bus_arb_cfg.sv
module bus_arb_cfg #(
  parameter int N_MOD  = 3,
  parameter int PRIO_W = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_MOD*PRIO_W-1:0] prio_a_i,
  input  logic [N_MOD*PRIO_W-1:0] prio_b_i,
  output logic [N_MOD*PRIO_W-1:0] eff_o
);
  logic cap_q;

  // capture window: reset and first edge after it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cap_q <= 1'b1;
    else         cap_q <= 1'b0;
  end

  for (genvar i = 0; i < N_MOD; i++) begin : g_mod
    logic [PRIO_W-1:0] a_q, b_q;
    always_ff @(posedge clk_i) begin
      if (cap_q) begin
        a_q <= prio_a_i[i*PRIO_W +: PRIO_W];
        b_q <= prio_b_i[i*PRIO_W +: PRIO_W];
      end
    end
    assign eff_o[i*PRIO_W +: PRIO_W] = (b_q < a_q) ? b_q : a_q;
  end
endmodule

// File: rtl/bus_arb_pick.sv
module bus_arb_pick #(
  parameter int N_MOD  = 3,
  parameter int PRIO_W = 3
) (
  input  logic [N_MOD-1:0]        req_i,
  input  logic [N_MOD*PRIO_W-1:0] eff_i,
  output logic [N_MOD-1:0]        pick_o,
  output logic                    any_o
);
  logic [PRIO_W-1:0] best;

  // strict compare keeps the lower index on ties
  always_comb begin
    any_o  = 1'b0;
    best   = '0;
    pick_o = '0;
    for (int i = 0; i < N_MOD; i++) begin
      if (req_i[i] && (!any_o || eff_i[i*PRIO_W +: PRIO_W] < best)) begin
        any_o     = 1'b1;
        best      = eff_i[i*PRIO_W +: PRIO_W];
        pick_o    = '0;
        pick_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bus_arb_cpu_split.sv
module bus_arb_cpu_split (
  input  logic iop_req_i,
  input  logic cpu_req_i,
  output logic iop_win_o,
  output logic cpu_win_o
);
  assign iop_win_o = iop_req_i;
  assign cpu_win_o = cpu_req_i & ~iop_req_i;
endmodule

// File: rtl/bus_arb.sv
module bus_arb
  import bus_arb_pkg::*;
#(
  parameter int N_MOD  = 3,
  parameter int PRIO_W = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_MOD*PRIO_W-1:0] prio_a_i,
  input  logic [N_MOD*PRIO_W-1:0] prio_b_i,
  input  logic [N_MOD-1:0]        req_i,
  input  logic [N_MOD-1:0]        rel_i,
  input  logic                    iop_req_i,
  input  logic                    iop_rel_i,
  input  logic                    cpu_req_i,
  input  logic                    cpu_rel_i,
  output logic [N_MOD-1:0]        gnt_o,
  output logic                    iop_gnt_o,
  output logic                    cpu_gnt_o,
  output logic                    busy_o
);
  localparam int NT = N_MOD + 2;

  logic [N_MOD*PRIO_W-1:0] eff;
  logic [N_MOD-1:0]        pick;
  logic                    mod_any;
  logic                    iop_win, cpu_win;
  logic [NT-1:0]           cand, rel_all, owner_q;
  arb_state_e              state_q;

  bus_arb_cfg #(.N_MOD(N_MOD), .PRIO_W(PRIO_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .prio_a_i (prio_a_i),
    .prio_b_i (prio_b_i),
    .eff_o    (eff)
  );

  bus_arb_pick #(.N_MOD(N_MOD), .PRIO_W(PRIO_W)) u_pick (
    .req_i  (req_i),
    .eff_i  (eff),
    .pick_o (pick),
    .any_o  (mod_any)
  );

  bus_arb_cpu_split u_split (
    .iop_req_i (iop_req_i),
    .cpu_req_i (cpu_req_i),
    .iop_win_o (iop_win),
    .cpu_win_o (cpu_win)
  );

  // processor slot only when no bus module asks
  assign cand    = mod_any ? {2'b00, pick} : {cpu_win, iop_win, {N_MOD{1'b0}}};
  assign rel_all = {cpu_rel_i, iop_rel_i, rel_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q <= '0;
      state_q <= ARB_FREE;
    end else begin
      case (state_q)
        ARB_FREE: if (|cand) begin
          owner_q <= cand;
          state_q <= ARB_OWNED;
        end
        ARB_OWNED: if (|(owner_q & rel_all)) begin
          owner_q <= '0;
          state_q <= ARB_FREE;
        end
        default: begin
          owner_q <= '0;
          state_q <= ARB_FREE;
        end
      endcase
    end
  end

  assign gnt_o     = owner_q[N_MOD-1:0];
  assign iop_gnt_o = owner_q[N_MOD];
  assign cpu_gnt_o = owner_q[N_MOD+1];
  assign busy_o    = (state_q == ARB_OWNED);
endmodule

// File: rtl/bus_arb_chk.sv
module bus_arb_chk #(
  parameter int N_MOD = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_MOD-1:0] req_i,
  input logic [N_MOD-1:0] rel_i,
  input logic             iop_req_i,
  input logic             iop_rel_i,
  input logic             cpu_req_i,
  input logic             cpu_rel_i,
  input logic [N_MOD-1:0] gnt_o,
  input logic             iop_gnt_o,
  input logic             cpu_gnt_o,
  input logic             busy_o
);
  localparam int NT = N_MOD + 2;
  logic [NT-1:0] g, r;
  logic          any_req;
  assign g       = {cpu_gnt_o, iop_gnt_o, gnt_o};
  assign r       = {cpu_rel_i, iop_rel_i, rel_i};
  assign any_req = (|req_i) | iop_req_i | cpu_req_i;

  AST_ONE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(g)); // R2
  AST_BUSY_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni) busy_o == (|g)); // R2
  AST_IDLE_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni) !busy_o && !any_req |=> !busy_o); // R3
  AST_GRANT_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni) !busy_o && any_req |=> busy_o); // R3
  AST_IOP_OVER_CPU: assert property (@(posedge clk_i) disable iff (!rst_ni) !busy_o && iop_req_i && !(|req_i) |=> iop_gnt_o); // R9
  AST_CPU_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(cpu_gnt_o) |-> $past(!(|req_i) && !iop_req_i)); // R8

  for (genvar i = 0; i < NT; i++) begin : g_own
    AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) g[i] && !r[i] |=> g[i]); // R6
    AST_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni) g[i] && r[i] |=> !busy_o); // R7
  end
endmodule

bind bus_arb bus_arb_chk #(.N_MOD(N_MOD)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .rel_i     (rel_i),
  .iop_req_i (iop_req_i),
  .iop_rel_i (iop_rel_i),
  .cpu_req_i (cpu_req_i),
  .cpu_rel_i (cpu_rel_i),
  .gnt_o     (gnt_o),
  .iop_gnt_o (iop_gnt_o),
  .cpu_gnt_o (cpu_gnt_o),
  .busy_o    (busy_o)
);

// File: tb/bus_arb_test.sv
module bus_arb_test;
  localparam int N_MOD  = 3;
  localparam int PRIO_W = 3;

  logic                    clk_i = 1'b0;
  logic                    rst_ni = 1'b0;
  logic [N_MOD*PRIO_W-1:0] prio_a_i, prio_b_i;
  logic [4:0]              req_v = '0, rel_v = '0;
  logic [N_MOD-1:0]        gnt_o;
  logic                    iop_gnt_o, cpu_gnt_o, busy_o;
  logic [4:0]              g;
  int                      total = 0, bad = 0;

  always #10 clk_i = ~clk_i;

  assign g = {cpu_gnt_o, iop_gnt_o, gnt_o};

  bus_arb #(.N_MOD(N_MOD), .PRIO_W(PRIO_W)) uut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .prio_a_i  (prio_a_i),
    .prio_b_i  (prio_b_i),
    .req_i     (req_v[2:0]),
    .rel_i     (rel_v[2:0]),
    .iop_req_i (req_v[3]),
    .iop_rel_i (rel_v[3]),
    .cpu_req_i (req_v[4]),
    .cpu_rel_i (rel_v[4]),
    .gnt_o     (gnt_o),
    .iop_gnt_o (iop_gnt_o),
    .cpu_gnt_o (cpu_gnt_o),
    .busy_o    (busy_o)
  );

  task automatic chk(string tag, logic [4:0] act, logic [4:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic do_reset(logic [8:0] a, logic [8:0] b);
    @(negedge clk_i);
    rst_ni = 1'b0; req_v = '0; rel_v = '0;
    prio_a_i = a; prio_b_i = b;
    repeat (3) @(negedge clk_i);
    chk("R1 grants in reset", g, 5'b0);
    chk("R1 busy in reset", {4'b0, busy_o}, 5'b0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
  endtask

  // owner k drops request and pulses release
  task automatic release_owner(int k, logic [4:0] exp_next, string tag);
    req_v[k] = 1'b0; rel_v[k] = 1'b1;
    @(negedge clk_i);
    rel_v[k] = 1'b0;
    chk("R7 free after release", g, 5'b0);
    chk("R7 busy low after release", {4'b0, busy_o}, 5'b0);
    @(negedge clk_i);
    chk(tag, g, exp_next);
  endtask

  // default cfg: m0 1/0, m1 2/3, m2 4/4
  task automatic t_simultaneous();
    do_reset({3'd4, 3'd2, 3'd1}, {3'd4, 3'd3, 3'd0});
    chk("R3 idle no grant", g, 5'b0);
    req_v = 5'b11111;
    @(negedge clk_i);
    chk("R3 lowest number wins", g, 5'b00001);
    chk("R2 busy with owner", {4'b0, busy_o}, 5'b00001);
    release_owner(0, 5'b00010, "R3 next module");
    release_owner(1, 5'b00100, "R3 selector slot");
    release_owner(2, 5'b01000, "R8 processor slot after modules");
    release_owner(3, 5'b10000, "R9 cpu last");
    release_owner(4, 5'b00000, "R3 no requests left");
  endtask

  task automatic t_no_preempt();
    do_reset({3'd4, 3'd2, 3'd1}, {3'd4, 3'd3, 3'd0});
    req_v[4] = 1'b1;
    @(negedge clk_i);
    chk("R8 cpu alone granted", g, 5'b10000);
    req_v[0] = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk("R6 owner kept", g, 5'b10000);
    end
    rel_v[0] = 1'b1;
    @(negedge clk_i);
    rel_v[0] = 1'b0;
    chk("R7 foreign release ignored", g, 5'b10000);
    @(negedge clk_i);
    chk("R6 busy held", {4'b0, busy_o}, 5'b00001);
    release_owner(4, 5'b00001, "R6 waiting module after release");
    release_owner(0, 5'b00000, "R3 bus idle");
  endtask

  task automatic t_iop_cpu();
    do_reset({3'd4, 3'd2, 3'd1}, {3'd4, 3'd3, 3'd0});
    req_v[4] = 1'b1; req_v[3] = 1'b1;
    @(negedge clk_i);
    chk("R9 iop over cpu", g, 5'b01000);
    release_owner(3, 5'b10000, "R9 cpu after iop");
    req_v[4] = 1'b0; rel_v[4] = 1'b1; req_v[2] = 1'b1; req_v[3] = 1'b1;
    @(negedge clk_i);
    rel_v[4] = 1'b0;
    @(negedge clk_i);
    chk("R8 module over iop", g, 5'b00100);
    release_owner(2, 5'b01000, "R9 iop next");
    release_owner(3, 5'b00000, "R3 idle");
  endtask

  task automatic t_cfg_frozen();
    do_reset({3'd4, 3'd2, 3'd1}, {3'd4, 3'd3, 3'd0});
    prio_a_i = {3'd0, 3'd3, 3'd7}; prio_b_i = {3'd0, 3'd3, 3'd7};
    repeat (2) @(negedge clk_i);
    req_v[0] = 1'b1; req_v[2] = 1'b1;
    @(negedge clk_i);
    chk("R10 cfg change after reset ignored", g, 5'b00001);
    release_owner(0, 5'b00100, "R10 other module next");
    release_owner(2, 5'b00000, "R3 idle");
  endtask

  task automatic t_tie();
    do_reset({3'd4, 3'd4, 3'd6}, {3'd4, 3'd4, 3'd6});
    req_v[1] = 1'b1; req_v[2] = 1'b1;
    @(negedge clk_i);
    chk("R4 tie to lower index", g, 5'b00010);
    release_owner(1, 5'b00100, "R4 tie loser next");
    release_owner(2, 5'b00000, "R3 idle");
  endtask

  task automatic t_dual();
    do_reset({3'd3, 3'd2, 3'd5}, {3'd3, 3'd2, 3'd1});
    req_v[0] = 1'b1; req_v[1] = 1'b1;
    @(negedge clk_i);
    chk("R5 second field used", g, 5'b00001);
    release_owner(0, 5'b00010, "R4 loser next");
    release_owner(1, 5'b00000, "R3 idle");
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    prio_a_i = '0; prio_b_i = '0;
    t_simultaneous();
    t_no_preempt();
    t_iop_cpu();
    t_cfg_frozen();
    t_tie();
    t_dual();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule